// File: doc/BRIEF.md
# Flash Register Guard

This block is the bus-facing register front end of an embedded flash controller. It accepts single-cycle 32-bit writes and reads from a simple valid/write bus. It holds the control word, three timing words, the operation address and the program-buffer index. It passes command requests and program-buffer data on to the operation sequencer, which sits outside this block.

A write-protect flag, set out of reset, makes the timing, address, program-buffer and control registers ignore bus writes. A blocked write raises a sticky error flag in the status word. Software clears that flag by writing a one to it.

The flag itself can only be changed by a control write that directly follows a three-write key sequence on the two unlock addresses. This holds even when protection is already off. One completed sequence admits exactly one control write.

Top module: `flash_reg_guard`

## Requirements
- R1: After reset the write-protect flag is 1, and sleep, command bits, status error, timing words, operation address and program-buffer index are all 0. The unlock sequence is idle, so a control write right after reset is blocked.
- R2: Word offsets are: control 0x00, timing0 0x04, timing1 0x08, timing2 0x0c, unlock1 0x18, unlock2 0x1c, operation address 0x20, program-buffer data 0x24, program-buffer index 0x28, status 0x2c. Reads return the current value of the register at that offset. Unlock addresses, program-buffer data and unmapped offsets read 0.
- R3: While write-protect (control bit 1) is 1, writes to timing0..2, operation address, program-buffer data and program-buffer index leave them unchanged and set status bit 1. So does a control write when no unlock is open.
- R4: The key sequence opens the unlock. It is a write of 0x00007123 to unlock1, then 0x0000812a to unlock2, then 0x0000bee1 to unlock1. The next control write is then taken in full, bit 1 included, with no error.
- R5: During the sequence, any bus write that is not the next expected step returns it to idle. A write of 0x00007123 to unlock1 always restarts it at the first step. Reads have no effect on the sequence.
- R6: An open unlock is consumed by one control write. It is cancelled by any other bus write.
- R7: With write-protect 0 and no unlock open, a control write updates sleep (bit 0) and the command bits, keeps bit 1 unchanged, and raises no error.
- R8: An accepted control write loads command bits 8:3 (bit 3 mass erase, 4 page erase, 5 program, 6 reference-cell erase, 7 trim recall, 8 auto-program). For exactly the following cycle, `cmd_op` carries them and `cmd_start` is high if any is set. Control bits 8:3 read back these bits in that cycle and read 0 afterwards.
- R9: Status bit 0 mirrors `seq_busy` and status bit 1 is the sticky error. Writing 1 to status bit 1 clears the error; writing 0 leaves it unchanged.
- R10: An accepted program-buffer data write pulses `pb_push` for one cycle, with the written word on `pb_wdata` and the index before the write on `pb_widx`. The index then advances by 4, wrapping modulo 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| seq_busy | input | 1 | Sequencer busy, shown in status bit 0 |
| ctl_wp | output | 1 | Write-protect flag |
| ctl_sleep | output | 1 | Sleep request |
| cmd_start | output | 1 | One-cycle command launch |
| cmd_op | output | 6 | Command bits 8:3 being launched |
| tim0 | output | 32 | Timing word 0 |
| tim1 | output | 32 | Timing word 1 |
| tim2 | output | 32 | Timing word 2 |
| op_addr | output | 32 | Erase/program address |
| pb_push | output | 1 | Program-buffer word strobe |
| pb_wdata | output | 32 | Program-buffer word |
| pb_widx | output | IDX_W | Byte index of that word |

## Verification
The assertions assume that `bus_valid`, `bus_write`, `bus_addr` and `bus_wdata` are known at every rising edge and change only between edges. They also assume at most one access per cycle. The stimulus drives all bus inputs on the falling edge and returns to idle between accesses. Random writes target only the ten mapped offsets and one unmapped offset. The data is biased toward the three key values, so that partial, broken and restarted sequences all occur often.

// File: rtl/flash_reg_guard.sv
module flash_reg_guard #(
  parameter int ADDR_W     = 6,
  parameter int PB_BYTES   = 32,
  parameter int WORD_BYTES = 4,
  localparam int IDX_W     = $clog2(PB_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              seq_busy,
  output logic              ctl_wp,
  output logic              ctl_sleep,
  output logic              cmd_start,
  output logic [5:0]        cmd_op,
  output logic [31:0]       tim0,
  output logic [31:0]       tim1,
  output logic [31:0]       tim2,
  output logic [31:0]       op_addr,
  output logic              pb_push,
  output logic [31:0]       pb_wdata,
  output logic [IDX_W-1:0]  pb_widx
);

  localparam logic [ADDR_W-1:0] OFS_CTL = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] OFS_T0  = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] OFS_T1  = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] OFS_T2  = ADDR_W'('h0c);
  localparam logic [ADDR_W-1:0] OFS_U1  = ADDR_W'('h18);
  localparam logic [ADDR_W-1:0] OFS_U2  = ADDR_W'('h1c);
  localparam logic [ADDR_W-1:0] OFS_ADR = ADDR_W'('h20);
  localparam logic [ADDR_W-1:0] OFS_PBD = ADDR_W'('h24);
  localparam logic [ADDR_W-1:0] OFS_PBI = ADDR_W'('h28);
  localparam logic [ADDR_W-1:0] OFS_ST  = ADDR_W'('h2c);

  localparam logic [31:0] KEY_A = 32'h0000_7123;
  localparam logic [31:0] KEY_B = 32'h0000_812a;
  localparam logic [31:0] KEY_C = 32'h0000_bee1;

  typedef enum logic [1:0] {UL_IDLE, UL_ONE, UL_TWO, UL_OPEN} ul_t;

  ul_t              ul_q, ul_d;
  logic             wp_q, sleep_q, err_q;
  logic [5:0]       cmd_q;
  logic [31:0]      t0_q, t1_q, t2_q, adr_q, pdat_q;
  logic [IDX_W-1:0] idx_q, pidx_q;
  logic             push_q;

  wire wr      = bus_valid & bus_write;
  wire hit_ctl = wr && bus_addr == OFS_CTL;
  wire hit_u1  = wr && bus_addr == OFS_U1;
  wire hit_u2  = wr && bus_addr == OFS_U2;
  wire hit_st  = wr && bus_addr == OFS_ST;
  wire hit_pbd = wr && bus_addr == OFS_PBD;
  wire hit_pbi = wr && bus_addr == OFS_PBI;
  wire hit_fld = wr && (bus_addr == OFS_T0 || bus_addr == OFS_T1 || bus_addr == OFS_T2 ||
                        bus_addr == OFS_ADR || bus_addr == OFS_PBD || bus_addr == OFS_PBI);

  wire ctl_open = hit_ctl && ul_q == UL_OPEN;
  wire ctl_take = hit_ctl && (ul_q == UL_OPEN || !wp_q);
  wire fld_take = hit_fld && !wp_q;
  wire blocked  = wp_q && (hit_fld || (hit_ctl && ul_q != UL_OPEN));

  always_comb begin
    ul_d = ul_q;
    if (wr) begin
      if (hit_u1 && bus_wdata == KEY_A)                      ul_d = UL_ONE;
      else if (ul_q == UL_ONE && hit_u2 && bus_wdata == KEY_B) ul_d = UL_TWO;
      else if (ul_q == UL_TWO && hit_u1 && bus_wdata == KEY_C) ul_d = UL_OPEN;
      else                                                   ul_d = UL_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ul_q    <= UL_IDLE;
      wp_q    <= 1'b1;
      sleep_q <= 1'b0;
      cmd_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      ul_q  <= ul_d;
      cmd_q <= ctl_take ? bus_wdata[8:3] : '0;
      if (ctl_take) sleep_q <= bus_wdata[0];
      if (ctl_open) wp_q <= bus_wdata[1];
      if (blocked) err_q <= 1'b1;
      else if (hit_st && bus_wdata[1]) err_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t0_q   <= '0;
      t1_q   <= '0;
      t2_q   <= '0;
      adr_q  <= '0;
      idx_q  <= '0;
      push_q <= 1'b0;
      pdat_q <= '0;
      pidx_q <= '0;
    end else begin
      push_q <= fld_take && hit_pbd;
      if (fld_take) begin
        case (bus_addr)
          OFS_T0:  t0_q  <= bus_wdata;
          OFS_T1:  t1_q  <= bus_wdata;
          OFS_T2:  t2_q  <= bus_wdata;
          OFS_ADR: adr_q <= bus_wdata;
          default: ;
        endcase
      end
      if (fld_take && hit_pbd) begin
        pdat_q <= bus_wdata;
        pidx_q <= idx_q;
        idx_q  <= idx_q + IDX_W'(WORD_BYTES);
      end
      if (fld_take && hit_pbi) idx_q <= bus_wdata[IDX_W-1:0];
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_CTL: bus_rdata = {23'd0, cmd_q, 1'b0, wp_q, sleep_q};
      OFS_T0:  bus_rdata = t0_q;
      OFS_T1:  bus_rdata = t1_q;
      OFS_T2:  bus_rdata = t2_q;
      OFS_ADR: bus_rdata = adr_q;
      OFS_PBI: bus_rdata = 32'(idx_q);
      OFS_ST:  bus_rdata = {30'd0, err_q, seq_busy};
      default: bus_rdata = 32'd0;
    endcase
  end

  assign ctl_wp    = wp_q;
  assign ctl_sleep = sleep_q;
  assign cmd_op    = cmd_q;
  assign cmd_start = |cmd_q;
  assign tim0      = t0_q;
  assign tim1      = t1_q;
  assign tim2      = t2_q;
  assign op_addr   = adr_q;
  assign pb_push   = push_q;
  assign pb_wdata  = pdat_q;
  assign pb_widx   = pidx_q;

  AST_BLOCKED_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    wp_q && hit_fld |=> err_q); // R3
  AST_BLOCKED_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    wp_q && hit_fld |=> $stable(tim0) && $stable(tim1) && $stable(tim2) && $stable(op_addr)); // R3
  AST_WP_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctl_wp) |-> $past(hit_ctl && ul_q == UL_OPEN)); // R4
  AST_OPEN_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_open |=> ul_q != UL_OPEN); // R6
  AST_CMD_FROM_CTL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |-> $past(hit_ctl)); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q && !(hit_st && bus_wdata[1]) |=> err_q); // R9
  AST_PUSH_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    pb_push |-> $past(hit_pbd && !wp_q)); // R10

endmodule

// File: tb/flash_reg_guard_tb.sv
module flash_reg_guard_tb;
  localparam int AW = 6;
  localparam int IW = 5;
  localparam logic [5:0] A_CTL = 6'h00, A_T0 = 6'h04, A_T1 = 6'h08, A_T2 = 6'h0c,
                         A_U1 = 6'h18, A_U2 = 6'h1c, A_ADR = 6'h20, A_PBD = 6'h24,
                         A_PBI = 6'h28, A_ST = 6'h2c, A_NONE = 6'h10;

  logic clk = 0, rst_n = 0;
  logic bus_valid = 0, bus_write = 0, seq_busy = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic ctl_wp, ctl_sleep, cmd_start, pb_push;
  logic [5:0] cmd_op;
  logic [31:0] tim0, tim1, tim2, op_addr, pb_wdata;
  logic [IW-1:0] pb_widx;

  always #2 clk = ~clk;

  flash_reg_guard u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .seq_busy(seq_busy), .ctl_wp(ctl_wp), .ctl_sleep(ctl_sleep),
    .cmd_start(cmd_start), .cmd_op(cmd_op), .tim0(tim0), .tim1(tim1), .tim2(tim2),
    .op_addr(op_addr), .pb_push(pb_push), .pb_wdata(pb_wdata), .pb_widx(pb_widx));

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic m_wp, m_sleep, m_err;
  logic [31:0] m_t0, m_t1, m_t2, m_ad, e_pdata;
  logic [IW-1:0] m_idx, e_pidx;
  logic [5:0] e_cmd;
  logic e_push;
  int m_ul;

  task automatic mdl_reset();
    m_wp = 1; m_sleep = 0; m_err = 0; m_t0 = 0; m_t1 = 0; m_t2 = 0; m_ad = 0;
    m_idx = 0; m_ul = 0; e_cmd = 0; e_push = 0; e_pdata = 0; e_pidx = 0;
  endtask

  task automatic mdl_write(input logic [5:0] a, input logic [31:0] d);
    bit open = (m_ul == 3);
    e_cmd = 0; e_push = 0;
    if (a == A_CTL) begin
      if (open) begin m_wp = d[1]; m_sleep = d[0]; e_cmd = d[8:3]; end
      else if (m_wp) m_err = 1;
      else begin m_sleep = d[0]; e_cmd = d[8:3]; end
    end else if (a == A_T0 || a == A_T1 || a == A_T2 || a == A_ADR || a == A_PBD || a == A_PBI) begin
      if (m_wp) m_err = 1;
      else case (a)
        A_T0: m_t0 = d;
        A_T1: m_t1 = d;
        A_T2: m_t2 = d;
        A_ADR: m_ad = d;
        A_PBI: m_idx = d[IW-1:0];
        default: begin e_push = 1; e_pdata = d; e_pidx = m_idx; m_idx = m_idx + 5'd4; end
      endcase
    end else if (a == A_ST && d[1]) m_err = 0;
    if (a == A_U1 && d == 32'h7123) m_ul = 1;
    else if (m_ul == 1 && a == A_U2 && d == 32'h812a) m_ul = 2;
    else if (m_ul == 2 && a == A_U1 && d == 32'hbee1) m_ul = 3;
    else m_ul = 0;
  endtask

  function automatic logic [31:0] exp_rd(input logic [5:0] a);
    case (a)
      A_CTL: return {30'd0, m_wp, m_sleep};
      A_T0: return m_t0;
      A_T1: return m_t1;
      A_T2: return m_t2;
      A_ADR: return m_ad;
      A_PBI: return 32'(m_idx);
      A_ST: return {30'd0, m_err, seq_busy};
      default: return 32'd0;
    endcase
  endfunction

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    mdl_write(a, d);
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
    chk("R8 cmd_start", 32'(cmd_start), 32'(|e_cmd));
    chk("R8 cmd_op", 32'(cmd_op), 32'(e_cmd));
    chk("R10 pb_push", 32'(pb_push), 32'(e_push));
    if (e_push) begin
      chk("R10 pb_wdata", pb_wdata, e_pdata);
      chk("R10 pb_widx", 32'(pb_widx), 32'(e_pidx));
    end
    chk("R3/R4/R7 ctl_wp", 32'(ctl_wp), 32'(m_wp));
    chk("R7 ctl_sleep", 32'(ctl_sleep), 32'(m_sleep));
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    #1 v = bus_rdata;
    bus_valid = 0;
  endtask

  task automatic chk_rd(input string req, input logic [5:0] a);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp_rd(a));
  endtask

  task automatic check_all(input string req);
    logic [5:0] lst[11] = '{A_CTL, A_T0, A_T1, A_T2, A_U1, A_U2, A_ADR, A_PBD, A_PBI, A_ST, A_NONE};
    foreach (lst[k]) chk_rd(req, lst[k]);
    chk("R2 tim0 port", tim0, m_t0);
    chk("R2 tim2 port", tim2, m_t2);
    chk("R2 op_addr port", op_addr, m_ad);
  endtask

  task automatic unlock();
    wr(A_U1, 32'h7123); wr(A_U2, 32'h812a); wr(A_U1, 32'hbee1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [5:0] addrs[11] = '{A_CTL, A_T0, A_T1, A_T2, A_U1, A_U2, A_ADR, A_PBD, A_PBI, A_ST, A_NONE};
    void'($urandom(32'd20240611));
    mdl_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 wp after reset", 32'(ctl_wp), 32'd1);
    chk("R1 cmd_start after reset", 32'(cmd_start), 32'd0);
    chk("R1 pb_push after reset", 32'(pb_push), 32'd0);
    check_all("R1 reset readback");

    wr(A_CTL, 32'h0);
    chk_rd("R1 control write blocked after reset", A_ST);

    wr(A_T0, 32'hdead_beef);
    chk_rd("R3 timing0 unchanged", A_T0);
    wr(A_ST, 32'h0);
    chk_rd("R9 write 0 keeps error", A_ST);
    wr(A_ST, 32'h2);
    chk_rd("R9 write 1 clears error", A_ST);

    unlock(); wr(A_CTL, 32'h0);
    chk_rd("R4 unlock clears wp, no error", A_ST);
    wr(A_T0, 32'h1234_5678); wr(A_T1, 32'h00aa_5500); wr(A_T2, 32'h0f0f_0f0f); wr(A_ADR, 32'h0000_3000);
    check_all("R2 readback unprotected");

    wr(A_CTL, 32'h3);
    chk("R7 wp kept without key", 32'(ctl_wp), 32'd0);
    chk_rd("R7 no error without key", A_ST);

    unlock(); wr(A_T1, 32'h1); wr(A_CTL, 32'h2);
    chk("R6 cancelled unlock keeps wp", 32'(ctl_wp), 32'd0);

    unlock(); wr(A_CTL, 32'h0); wr(A_CTL, 32'h2);
    chk("R6 second write not admitted", 32'(ctl_wp), 32'd0);

    wr(A_U1, 32'h7123); wr(A_U2, 32'h812a); chk_rd("R5 read during sequence", A_CTL);
    wr(A_U1, 32'hbee1); wr(A_CTL, 32'h2);
    chk("R5 read does not break sequence", 32'(ctl_wp), 32'd1);

    wr(A_ST, 32'h2);
    wr(A_U1, 32'h7123); wr(A_U2, 32'h1111); wr(A_U1, 32'hbee1); wr(A_CTL, 32'h0);
    chk("R5 broken order keeps wp", 32'(ctl_wp), 32'd1);
    chk_rd("R5 broken order error", A_ST);
    wr(A_U1, 32'h7123); wr(A_U1, 32'h7123); wr(A_U2, 32'h812a); wr(A_U1, 32'hbee1); wr(A_CTL, 32'h0);
    chk("R5 restart on first key", 32'(ctl_wp), 32'd0);

    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = A_CTL; bus_wdata = 32'h1f9;
    mdl_write(A_CTL, 32'h1f9);
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
    #1 chk("R8 command bits read during pulse", bus_rdata, 32'h1f9);
    chk("R8 cmd_start high", 32'(cmd_start), 32'd1);
    chk("R8 cmd_op value", 32'(cmd_op), 32'h3f);
    @(negedge clk);
    #1 chk("R8 command bits cleared", bus_rdata, 32'h1);
    chk("R8 cmd_start low", 32'(cmd_start), 32'd0);

    wr(A_PBI, 32'd28);
    wr(A_PBD, 32'hcafe_0001);
    wr(A_PBD, 32'hcafe_0002);
    chk_rd("R10 index wrapped", A_PBI);

    for (int i = 0; i < 600; i++) begin
      int sel = $urandom_range(0, 9);
      logic [31:0] d;
      seq_busy = 1'($urandom_range(0, 1));
      if (sel < 2) begin
        unlock();
        wr(A_CTL, $urandom & 32'h1fb);
      end else begin
        int k = $urandom_range(0, 3);
        d = (k == 0) ? 32'h7123 : (k == 1) ? 32'h812a : (k == 2) ? 32'hbee1 : $urandom;
        if ($urandom_range(0, 1) == 0) d = $urandom;
        wr(addrs[$urandom_range(0, 10)], d);
      end
      chk_rd("R9 status random", A_ST);
      if (i % 16 == 0) check_all("R2 random readback");
    end
    check_all("R2 final readback");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule